// File: doc/BRIEF.md
# Mute-Pin Power-Down Controller

This block turns an asynchronous external mute pin into a set of power-down requests for the analog front end and the serial audio port. The pin is brought into the system clock domain through a two-flop synchronizer, and a programmable polarity bit then decides whether a high or a low level counts as asserted. While mute is asserted, two 8-bit control registers choose which units are asked to power down. The targets are the four ADC channels, the references, four microphone bias generators, the two serial data outputs and the TDM interface.

Some enables cover a whole group of units and others cover a single unit. The TDM enable only works together with the serial-output-1 enable. The serial-output-2 enable is disregarded while TDM mode is on. Every power-down output is the OR of the mute-driven request and a normal power-down input for that unit. Releasing mute therefore removes only the part of the request that mute added. All outputs are registered.

Top module: `mute_pd_ctrl`

## Requirements
- R1: After reset the group register (address 0) reads 0x00, the channel register (address 1) reads 0x80, and all power-down outputs are 0.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` in the register chosen by `reg_addr_i`, and the new value is visible on `reg_rdata_o` after that clock edge. Bit 5 of the group register is reserved: it is not stored and always reads 0.
- R3: Bit 7 of the channel register sets the pin polarity: 1 means a high level asserts mute, 0 means a low level asserts mute. After a pin change, the outputs respond on the third rising clock edge.
- R4: With mute asserted, group register bit 7 powers down all four ADCs, the references and all four mic biases.
- R5: With mute asserted, group register bit 6 powers down all ADCs and all mic biases and leaves the references on.
- R6: With mute asserted, group register bits 4..1 power down mic biases 4..1 (`bias_pd_o[3:0]`) one each, and bit 0 powers down all four biases.
- R7: With mute asserted, channel register bits 3..0 power down ADC channels 2B, 2A, 1B and 1A, mapped onto `adc_pd_o[3:0]`.
- R8: With mute asserted, channel register bit 4 powers down serial output 1. Bit 6 powers down the TDM interface only when bit 4 is also set.
- R9: With mute asserted, channel register bit 5 powers down serial output 2 only while `tdm_mode_i` is low. In TDM mode it has no effect.
- R10: Each output is the OR of its normal power-down input and the mute request, registered once. Deasserting mute clears only the mute-driven part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mute_pin_i | input | 1 | Asynchronous external mute pin |
| tdm_mode_i | input | 1 | Serial port is in TDM mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the group register, 1 selects the channel register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| adc_pd_i | input | 4 | Normal ADC power-down requests (1A,1B,2A,2B at bits 0..3) |
| ref_pd_i | input | 1 | Normal reference power-down request |
| bias_pd_i | input | 4 | Normal mic bias power-down requests (bias 1..4 at bits 0..3) |
| sdout_pd_i | input | 2 | Normal serial output power-down requests (output 1 at bit 0) |
| tdm_pd_i | input | 1 | Normal TDM interface power-down request |
| adc_pd_o | output | 4 | ADC channel power-down outputs |
| ref_pd_o | output | 1 | Reference power-down output |
| bias_pd_o | output | 4 | Mic bias power-down outputs |
| sdout_pd_o | output | 2 | Serial output power-down outputs |
| tdm_pd_o | output | 1 | TDM interface power-down output |

## Verification
A register write can land in the same cycle in which a synchronized pin edge reaches the decode stage. The output stage must then combine the new enables with the new mute level. The bench provokes this directly: it writes the group register on the second clock edge after a pin rise, when the second synchronizer flop updates. It then expects the full group power-down on the third edge. A second case releases mute while normal power-down inputs are held. The bench predicts the outputs from its own model and expects only the mute-driven bits to clear.

// File: rtl/mute_pd_pkg.sv
package mute_pd_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_ADC  = 4;
  localparam int unsigned NUM_BIAS = 4;
  localparam int unsigned NUM_SD   = 2;

  typedef struct packed {
    logic                pdn_all;   // adc + ref + bias
    logic                pdn_core;  // adc + bias
    logic [NUM_BIAS-1:0] bias_sel;
    logic                bias_all;
  } grp_cfg_t;

  typedef struct packed {
    logic               pol_high;
    logic               tdm_en;
    logic               sd2_en;
    logic               sd1_en;
    logic [NUM_ADC-1:0] adc_sel;
  } chan_cfg_t;

  typedef struct packed {
    logic                tdm;
    logic [NUM_SD-1:0]   sd;
    logic                refs;
    logic [NUM_BIAS-1:0] bias;
    logic [NUM_ADC-1:0]  adc;
  } pd_vec_t;

  localparam grp_cfg_t  GRP_RST  = '0;
  localparam chan_cfg_t CHAN_RST = '{pol_high: 1'b1, default: '0};
endpackage

// File: rtl/mute_pin_sync.sv
module mute_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_o = sync_q[STAGES-1];

  assert_sync_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> pin_o == $past(sync_q[STAGES-2]));
endmodule

// File: rtl/mute_pd_regs.sv
module mute_pd_regs
  import mute_pd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output grp_cfg_t         grp_o,
  output chan_cfg_t        chan_o
);
  grp_cfg_t  grp_q;
  chan_cfg_t chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= GRP_RST;
      chan_q <= CHAN_RST;
    end else if (we_i) begin
      if (!addr_i) grp_q <= '{pdn_all: wdata_i[7], pdn_core: wdata_i[6],
                              bias_sel: wdata_i[4:1], bias_all: wdata_i[0]};
      else         chan_q <= chan_cfg_t'(wdata_i);
    end
  end

  assign rdata_o = addr_i ? REG_W'(chan_q)
                          : {grp_q.pdn_all, grp_q.pdn_core, 1'b0, grp_q.bias_sel, grp_q.bias_all};
  assign grp_o   = grp_q;
  assign chan_o  = chan_q;

  assert_chan_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i |=> REG_W'(chan_q) == $past(wdata_i));
  assert_grp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i) |=> $stable(grp_q));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> rdata_o[5] == 1'b0);
endmodule

// File: rtl/mute_pd_decode.sv
module mute_pd_decode
  import mute_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_sync_i,
  input  logic      tdm_mode_i,
  input  grp_cfg_t  grp_i,
  input  chan_cfg_t chan_i,
  input  pd_vec_t   norm_i,
  output pd_vec_t   pd_o
);
  logic    mute_act;
  pd_vec_t mute_req;
  pd_vec_t pd_q;

  assign mute_act = (pin_sync_i == chan_i.pol_high);

  always_comb begin
    mute_req      = '0;
    mute_req.adc  = {NUM_ADC{grp_i.pdn_all | grp_i.pdn_core}} | chan_i.adc_sel;
    mute_req.refs = grp_i.pdn_all;
    mute_req.bias = {NUM_BIAS{grp_i.pdn_all | grp_i.pdn_core | grp_i.bias_all}} | grp_i.bias_sel;
    mute_req.sd[0] = chan_i.sd1_en;
    mute_req.sd[1] = chan_i.sd2_en & ~tdm_mode_i;
    mute_req.tdm  = chan_i.tdm_en & chan_i.sd1_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= '0;
    else         pd_q <= norm_i | (mute_act ? mute_req : pd_vec_t'('0));
  end

  assign pd_o = pd_q;

  assert_ref_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o.refs |-> $past(norm_i.refs || (mute_act && grp_i.pdn_all)));
  assert_tdm_dep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o.tdm && !$past(norm_i.tdm) |-> $past(chan_i.sd1_en && chan_i.tdm_en));
  assert_sd2_tdm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o.sd[1] && $past(tdm_mode_i) |-> $past(norm_i.sd[1]));
  assert_norm_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (pd_o & $past(norm_i)) == $past(norm_i));
endmodule

// File: rtl/mute_pd_ctrl.sv
module mute_pd_ctrl
  import mute_pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mute_pin_i,
  input  logic                tdm_mode_i,
  input  logic                reg_we_i,
  input  logic                reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [NUM_ADC-1:0]  adc_pd_i,
  input  logic                ref_pd_i,
  input  logic [NUM_BIAS-1:0] bias_pd_i,
  input  logic [NUM_SD-1:0]   sdout_pd_i,
  input  logic                tdm_pd_i,
  output logic [NUM_ADC-1:0]  adc_pd_o,
  output logic                ref_pd_o,
  output logic [NUM_BIAS-1:0] bias_pd_o,
  output logic [NUM_SD-1:0]   sdout_pd_o,
  output logic                tdm_pd_o
);
  logic      pin_sync;
  grp_cfg_t  grp_cfg;
  chan_cfg_t chan_cfg;
  pd_vec_t   norm_pd;
  pd_vec_t   out_pd;

  mute_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (mute_pin_i),
    .pin_o  (pin_sync)
  );

  mute_pd_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .grp_o   (grp_cfg),
    .chan_o  (chan_cfg)
  );

  assign norm_pd = '{tdm: tdm_pd_i, sd: sdout_pd_i, refs: ref_pd_i,
                     bias: bias_pd_i, adc: adc_pd_i};

  mute_pd_decode i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .tdm_mode_i (tdm_mode_i),
    .grp_i      (grp_cfg),
    .chan_i     (chan_cfg),
    .norm_i     (norm_pd),
    .pd_o       (out_pd)
  );

  assign adc_pd_o   = out_pd.adc;
  assign ref_pd_o   = out_pd.refs;
  assign bias_pd_o  = out_pd.bias;
  assign sdout_pd_o = out_pd.sd;
  assign tdm_pd_o   = out_pd.tdm;
endmodule

// File: tb/test_mute_pd_ctrl.sv
module test_mute_pd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, tdm = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] adc_i = '0, bias_i = '0, adc_o, bias_o;
  logic       ref_i = 1'b0, tdm_i = 1'b0, ref_o, tdm_o;
  logic [1:0] sd_i = '0, sd_o;
  int         errors = 0, checks = 0;
  logic [7:0] m_grp = 8'h00, m_chan = 8'h80;

  always #10 clk = ~clk;

  mute_pd_ctrl i_mute_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mute_pin_i(pin), .tdm_mode_i(tdm),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .adc_pd_i(adc_i), .ref_pd_i(ref_i), .bias_pd_i(bias_i), .sdout_pd_i(sd_i),
    .tdm_pd_i(tdm_i), .adc_pd_o(adc_o), .ref_pd_o(ref_o), .bias_pd_o(bias_o),
    .sdout_pd_o(sd_o), .tdm_pd_o(tdm_o));

  // {tdm, sd[1:0], ref, bias[3:0], adc[3:0]}
  function automatic logic [11:0] model(logic [7:0] g, logic [7:0] c, logic p, logic t,
                                        logic [11:0] norm);
    logic [11:0] r = '0;
    logic        m = (p == c[7]);
    if (m) begin
      r[3:0]  = {4{g[7] | g[6]}} | c[3:0];
      r[7:4]  = {4{g[7] | g[6] | g[0]}} | g[4:1];
      r[8]    = g[7];
      r[9]    = c[4];
      r[10]   = c[5] & ~t;
      r[11]   = c[6] & c[4];
    end
    return r | norm;
  endfunction

  function automatic logic [11:0] outs();
    return {tdm_o, sd_o, ref_o, bias_o, adc_o};
  endfunction
  function automatic logic [11:0] norms();
    return {tdm_i, sd_i, ref_i, bias_i, adc_i};
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    if (a) m_chan = d; else m_grp = d & 8'hDF;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_model(string req);
    chk(req, outs(), model(m_grp, m_chan, pin, tdm, norms()));
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    addr = 1'b0; #1 chk("R1", {4'h0, rdata}, 12'h000);
    addr = 1'b1; #1 chk("R1", {4'h0, rdata}, 12'h080);
    chk("R1", outs(), 12'h000);

    // R2 readback and reserved bit
    wr(1'b0, 8'hFF); addr = 1'b0; #1 chk("R2", {4'h0, rdata}, 12'h0DF);
    wr(1'b1, 8'h5A); addr = 1'b1; #1 chk("R2", {4'h0, rdata}, 12'h05A);

    // R3 latency: pin high, active high, all adc enables
    wr(1'b0, 8'h00); wr(1'b1, 8'h8F); settle();
    chk("R3", outs(), 12'h000);
    pin = 1'b1;
    @(negedge clk); chk("R3", outs(), 12'h000);
    @(negedge clk); chk("R3", outs(), 12'h000);
    @(negedge clk); chk("R3", outs(), 12'h00F);
    // R3 polarity low: pin high is now inactive
    wr(1'b1, 8'h0F); settle(); chk("R3", outs(), 12'h000);
    pin = 1'b0; settle(); chk("R3", outs(), 12'h00F);

    // R4/R5 group enables with active-high pin asserted
    wr(1'b1, 8'h80); pin = 1'b1;
    wr(1'b0, 8'h80); settle(); chk("R4", outs(), 12'h1FF);
    wr(1'b0, 8'h40); settle(); chk("R5", outs(), 12'h0FF);
    // R6 individual biases and all-bias
    wr(1'b0, 8'h04); settle(); chk("R6", outs(), 12'h020);
    wr(1'b0, 8'h10); settle(); chk("R6", outs(), 12'h080);
    wr(1'b0, 8'h01); settle(); chk("R6", outs(), 12'h0F0);
    // R7 individual adc
    wr(1'b0, 8'h00); wr(1'b1, 8'h84); settle(); chk("R7", outs(), 12'h004);
    // R8 tdm needs sd1
    wr(1'b1, 8'hC0); settle(); chk("R8", outs(), 12'h000);
    wr(1'b1, 8'hD0); settle(); chk("R8", outs(), 12'hA00);
    // R9 sd2 ignored in tdm mode
    wr(1'b1, 8'hA0); tdm = 1'b0; settle(); chk("R9", outs(), 12'h400);
    tdm = 1'b1; settle(); chk("R9", outs(), 12'h000);
    tdm = 1'b0;

    // R10 release keeps normal requests
    wr(1'b0, 8'h80); wr(1'b1, 8'hFF);
    ref_i = 1'b1; bias_i = 4'h2; settle(); chk("R10", outs(), 12'hFFF);
    pin = 1'b0; settle(); chk("R10", outs(), 12'h120);
    ref_i = 1'b0; bias_i = 4'h0;
    @(negedge clk); chk("R10", outs(), 12'h000);

    // Same-cycle: write lands when synced pin reaches decode (R4)
    wr(1'b0, 8'h00); wr(1'b1, 8'h80); settle();
    pin = 1'b1; addr = 1'b0; wdata = 8'h80;
    @(negedge clk); we = 1'b1;
    @(negedge clk); we = 1'b0; m_grp = 8'h80;
    chk("R4", outs(), 12'h000);
    @(negedge clk); chk("R4", outs(), 12'h1FF);

    // random mix
    for (int i = 0; i < 60; i++) begin
      wr(1'b0, 8'($urandom)); wr(1'b1, 8'($urandom));
      pin = 1'($urandom); tdm = 1'($urandom);
      {tdm_i, sd_i, ref_i, bias_i, adc_i} = 12'($urandom) & {12{($urandom % 3) == 0}};
      settle();
      expect_model("R10");
      addr = 1'($urandom); #1
      chk("R2", {4'h0, rdata}, {4'h0, addr ? m_chan : m_grp});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule